// File: doc/BRIEF.md
# Three-Bank Level Interrupt Register File

This block holds the software-visible state of a 96-line interrupt controller. The lines are grouped into three banks of 32. Every line is level sensitive. A line's pending bit is set by a high input, by a software request, or by both. The block keeps a mask and a class steer (normal or fast) for each line, plus a 6-bit priority. It presents pending, mask, steer and priority as flat vectors to a priority arbiter that sits outside it. It also gives that arbiter a one-cycle re-evaluation pulse, two re-arm strobes and a global mask level.

Software reaches the block through a simple word-addressed port inside a 4 KB window. A write takes effect at the clock edge where `wr_en` is sampled. A read returns its data on `rdata` one cycle after `rd_en`. Reads have no side effects.

The map is as follows:
- Bank registers are at byte address 0x80 + 0x20×bank.
- Per-line configuration words are at 0x100 + 0x80×bank + 4×line.
- Global registers sit in the low part of the window.

Address bits [1:0] are ignored.

Top module: `irq_bank_regfile`

## Requirements
- R1: After `rst_n` is low, every mask bit is 1. Pending, software, steer and priority state are 0. The global mask, autoidle, idle field, re-arm strobes and `eval_o` are 0.
- R2: An input line sampled high after being sampled low sets its pending bit at that edge and pulses `eval_o` for one cycle. The raw input view at bank offset +0x00 returns the sampled input levels.
- R3: When any input of a bank is sampled falling, that bank's pending vector becomes the bank's current input levels OR its software vector.
- R4: Software-set (+0x10) ORs the written bits into the software vector, then ORs the whole updated software vector into pending, and pulses `eval_o`. Reading +0x10 returns the software vector. Software-clear (+0x14) clears the written bits in the software vector, then sets pending to software AND current inputs, and gives no pulse.
- R5: The mask register at +0x04 is replaced on write. Mask-clear at +0x08 clears the written bits. Mask-set at +0x0C sets the written bits. A write to +0x04 or +0x08 pulses `eval_o`; a write to +0x0C does not.
- R6: The normal pending view at +0x18 reads pending & ~mask & ~steer. The fast pending view at +0x1C reads pending & ~mask & steer.
- R7: A configuration word write stores bit 0 as the line's steer (1 = fast) and bits 7:2 as its priority. A read returns {priority, 0, steer} in bits 7:0. Both values appear on `steer_o` and `prio_o`.
- R8: The register at 0x00 reads 0x21. The register at 0x14 reads 1 (reset done). The register at 0x4C reads 0.
- R9: At 0x10, bit 0 is an autoidle bit that reads back. Writing bit 1 as 1 returns all state to its R1 values, including the sampled inputs; `rdata` is not affected.
- R10: At 0x48, bit 2 is the global mask. It reads back in bit 2 and drives `glob_mask_o`. Writing bit 0 or bit 1 as 1 gives a one-cycle pulse on `rearm_norm_o` or `rearm_fast_o`, respectively, in the next cycle.
- R11: The register at 0x50 stores and returns 2 bits.
- R12: A bank index of 3 in the bank window is rejected: writes are ignored and reads return 0. Writes to read-only registers (raw input, both pending views, 0x00, 0x14) are ignored. Unmapped addresses read 0.
- R13: `rdata` presents the value addressed in the cycle `rd_en` was high, one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | NB*32 | Level interrupt requests, line 32×bank+n |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte address in the 4 KB window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after `rd_en` |
| pend_o | output | NB*32 | Pending vector |
| mask_o | output | NB*32 | Mask vector (1 = masked) |
| steer_o | output | NB*32 | Class steer (1 = fast) |
| prio_o | output | NB*32*PRIO_W | Per-line priority, line-major |
| glob_mask_o | output | 1 | Global mask level |
| rearm_norm_o | output | 1 | Normal channel re-arm pulse |
| rearm_fast_o | output | 1 | Fast channel re-arm pulse |
| eval_o | output | 1 | Re-evaluation request pulse |

## Verification
The state outputs and the pulses each register exactly once. Those outputs are `pend_o`, `mask_o`, `steer_o`, `prio_o` and `glob_mask_o`; the pulses are `eval_o` and the two re-arm strobes. Each is therefore due at the first rising edge after the input or write that causes it. Read data arrives on the rising edge after `rd_en` and reflects the state before that edge. The bench drives all inputs at the falling edge. It computes the expected read value from its model before the edge, advances the model at the rising edge, and compares every output at the following falling edge.

// File: rtl/irq_bank_regfile.sv
module irq_bank_regfile #(
  parameter int NB = 3,
  parameter int PRIO_W = 6,
  parameter logic [7:0] REV = 8'h21
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NB*32-1:0]         irq_in,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [11:0]              addr,
  input  logic [31:0]              wdata,
  output logic [31:0]              rdata,
  output logic [NB*32-1:0]         pend_o,
  output logic [NB*32-1:0]         mask_o,
  output logic [NB*32-1:0]         steer_o,
  output logic [NB*32*PRIO_W-1:0]  prio_o,
  output logic                     glob_mask_o,
  output logic                     rearm_norm_o,
  output logic                     rearm_fast_o,
  output logic                     eval_o
);
  localparam int LN = 32;
  localparam int W = NB * LN;
  localparam int CBASE = 2;
  localparam logic [9:0] A_SYSCFG = 10'd4;
  localparam logic [9:0] A_STAT = 10'd5;
  localparam logic [9:0] A_CTRL = 10'd18;
  localparam logic [9:0] A_IDLE = 10'd20;

  logic [9:0] wa;
  logic [4:0] blk;
  logic [1:0] bsel;
  logic [2:0] boff;
  logic [4:0] cline;
  logic       bok, cwin, wr_bank, wr_cfg, wr_ctl, srst;

  assign wa    = addr[11:2];
  assign blk   = addr[11:7];
  assign bsel  = addr[6:5];
  assign boff  = addr[4:2];
  assign cline = addr[6:2];
  assign bok   = (blk == 5'd1) && (int'(bsel) < NB);
  assign cwin  = (int'(blk) >= CBASE) && (int'(blk) < CBASE + NB);
  assign wr_bank = wr_en && bok;
  assign wr_cfg  = wr_en && cwin;
  assign wr_ctl  = wr_en && (wa == A_CTRL);
  assign srst    = wr_en && (wa == A_SYSCFG) && wdata[1];

  logic [W-1:0] in_q, pend_q, swi_q, mask_q, steer_q;
  logic [W-1:0] pend_n, swi_n, mask_n, steer_n;
  logic [W-1:0] up, dn;
  logic [PRIO_W-1:0] prio_q [NB][LN];
  logic autoidle_q, gm_q, rn_q, rf_q, eval_q, eval_n;
  logic [1:0] idle_q;
  logic [31:0] rd_n;

  assign up = irq_in & ~in_q;
  assign dn = ~irq_in & in_q;

  always_comb begin
    pend_n  = pend_q;
    swi_n   = swi_q;
    mask_n  = mask_q;
    steer_n = steer_q;
    eval_n  = |up;
    for (int b = 0; b < NB; b++) begin
      if (|dn[b*LN +: LN])
        pend_n[b*LN +: LN] = irq_in[b*LN +: LN] | swi_q[b*LN +: LN];
      else
        pend_n[b*LN +: LN] = pend_q[b*LN +: LN] | up[b*LN +: LN];
      if (wr_bank && bsel == 2'(b)) begin
        case (boff)
          3'd1: begin
            mask_n[b*LN +: LN] = wdata;
            eval_n = 1'b1;
          end
          3'd2: begin
            mask_n[b*LN +: LN] = mask_q[b*LN +: LN] & ~wdata;
            eval_n = 1'b1;
          end
          3'd3: mask_n[b*LN +: LN] = mask_q[b*LN +: LN] | wdata;
          3'd4: begin
            swi_n[b*LN +: LN]  = swi_q[b*LN +: LN] | wdata;
            pend_n[b*LN +: LN] = pend_n[b*LN +: LN] | swi_n[b*LN +: LN];
            eval_n = 1'b1;
          end
          3'd5: begin
            swi_n[b*LN +: LN]  = swi_q[b*LN +: LN] & ~wdata;
            pend_n[b*LN +: LN] = swi_n[b*LN +: LN] & irq_in[b*LN +: LN];
          end
          default: ;
        endcase
      end
      if (wr_cfg && blk == 5'(CBASE + b))
        steer_n[b*LN + int'(cline)] = wdata[0];
    end
  end

  always_comb begin
    rd_n = '0;
    if (bok) begin
      for (int b = 0; b < NB; b++) begin
        if (bsel == 2'(b)) begin
          case (boff)
            3'd0: rd_n = in_q[b*LN +: LN];
            3'd1: rd_n = mask_q[b*LN +: LN];
            3'd4: rd_n = swi_q[b*LN +: LN];
            3'd6: rd_n = pend_q[b*LN +: LN] & ~mask_q[b*LN +: LN] & ~steer_q[b*LN +: LN];
            3'd7: rd_n = pend_q[b*LN +: LN] & ~mask_q[b*LN +: LN] & steer_q[b*LN +: LN];
            default: rd_n = '0;
          endcase
        end
      end
    end else if (cwin) begin
      for (int b = 0; b < NB; b++) begin
        if (blk == 5'(CBASE + b))
          rd_n[PRIO_W+1:0] = {prio_q[b][cline], 1'b0, steer_q[b*LN + int'(cline)]};
      end
    end else begin
      case (wa)
        10'd0:    rd_n = 32'(REV);
        A_SYSCFG: rd_n[0] = autoidle_q;
        A_STAT:   rd_n[0] = 1'b1;
        A_CTRL:   rd_n[2] = gm_q;
        A_IDLE:   rd_n[1:0] = idle_q;
        default:  rd_n = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      rn_q <= 1'b0;
      rf_q <= 1'b0;
      in_q <= '0;
      pend_q <= '0;
      swi_q <= '0;
      mask_q <= '1;
      steer_q <= '0;
      eval_q <= 1'b0;
      autoidle_q <= 1'b0;
      gm_q <= 1'b0;
      idle_q <= '0;
      for (int b = 0; b < NB; b++)
        for (int l = 0; l < LN; l++)
          prio_q[b][l] <= '0;
    end else begin
      if (rd_en)
        rdata <= rd_n;
      rn_q <= wr_ctl && wdata[0];
      rf_q <= wr_ctl && wdata[1];
      if (srst) begin
        in_q <= '0;
        pend_q <= '0;
        swi_q <= '0;
        mask_q <= '1;
        steer_q <= '0;
        eval_q <= 1'b0;
        autoidle_q <= 1'b0;
        gm_q <= 1'b0;
        idle_q <= '0;
        for (int b = 0; b < NB; b++)
          for (int l = 0; l < LN; l++)
            prio_q[b][l] <= '0;
      end else begin
        in_q <= irq_in;
        pend_q <= pend_n;
        swi_q <= swi_n;
        mask_q <= mask_n;
        steer_q <= steer_n;
        eval_q <= eval_n;
        if (wr_en && wa == A_SYSCFG)
          autoidle_q <= wdata[0];
        if (wr_ctl)
          gm_q <= wdata[2];
        if (wr_en && wa == A_IDLE)
          idle_q <= wdata[1:0];
        for (int b = 0; b < NB; b++)
          if (wr_cfg && blk == 5'(CBASE + b))
            prio_q[b][cline] <= wdata[2 +: PRIO_W];
      end
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    for (genvar l = 0; l < LN; l++) begin : g_line
      assign prio_o[(b*LN + l)*PRIO_W +: PRIO_W] = prio_q[b][l];
    end
  end

  assign pend_o       = pend_q;
  assign mask_o       = mask_q;
  assign steer_o      = steer_q;
  assign glob_mask_o  = gm_q;
  assign rearm_norm_o = rn_q;
  assign rearm_fast_o = rf_q;
  assign eval_o       = eval_q;
endmodule

// File: rtl/irq_bank_regfile_chk.sv
module irq_bank_regfile_chk #(
  parameter int NB = 3,
  parameter logic [7:0] REV = 8'h21
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             rd_en,
  input logic [11:0]      addr,
  input logic [31:0]      wdata,
  input logic [31:0]      rdata,
  input logic [NB*32-1:0] mask_o,
  input logic [NB*32-1:0] steer_o,
  input logic             rearm_norm_o,
  input logic             rearm_fast_o
);
  // R5
  mask_fall_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(mask_o) & ~mask_o)) |-> $past(wr_en));

  // R7
  steer_change_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(steer_o) |-> $past(wr_en));

  // R10
  rearm_norm_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_norm_o |-> $past(wr_en && addr[11:2] == 10'd18 && wdata[0]));

  // R10
  rearm_fast_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_fast_o |-> $past(wr_en && addr[11:2] == 10'd18 && wdata[1]));

  // R8
  revision_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr[11:2] == 10'd0) |=> (rdata == 32'(REV)));

  // R12
  bad_bank_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[11:7] == 5'd1 && int'(addr[6:5]) >= NB) |=> ($stable(mask_o) && $stable(steer_o)));
endmodule

bind irq_bank_regfile irq_bank_regfile_chk #(.NB(NB), .REV(REV)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .mask_o(mask_o), .steer_o(steer_o),
  .rearm_norm_o(rearm_norm_o), .rearm_fast_o(rearm_fast_o)
);

// File: tb/irq_bank_regfile_bench.sv
`timescale 1ns/100ps
module irq_bank_regfile_bench;
  localparam int NB = 3;
  localparam int LN = 32;
  localparam int PW = 6;
  localparam int W = NB * LN;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] irq_in = '0;
  logic wr_en = 1'b0;
  logic rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [W-1:0] pend_o, mask_o, steer_o;
  logic [W*PW-1:0] prio_o;
  logic glob_mask_o, rearm_norm_o, rearm_fast_o, eval_o;

  always #2.5 clk = ~clk;

  irq_bank_regfile #(.NB(NB), .PRIO_W(PW), .REV(8'h21)) u_irq_bank_regfile (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pend_o(pend_o), .mask_o(mask_o),
    .steer_o(steer_o), .prio_o(prio_o), .glob_mask_o(glob_mask_o),
    .rearm_norm_o(rearm_norm_o), .rearm_fast_o(rearm_fast_o), .eval_o(eval_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [W-1:0] m_in, m_pend, m_swi, m_mask, m_steer;
  logic [PW-1:0] m_prio [NB][LN];
  logic m_ai, m_gm, m_ev, m_rn, m_rf;
  logic [1:0] m_idle;

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic m_reset();
    m_in = '0; m_pend = '0; m_swi = '0; m_mask = '1; m_steer = '0;
    m_ai = 1'b0; m_gm = 1'b0; m_idle = '0; m_ev = 1'b0;
    for (int b = 0; b < NB; b++)
      for (int l = 0; l < LN; l++)
        m_prio[b][l] = '0;
  endtask

  function automatic logic [31:0] m_read(logic [11:0] a);
    int b;
    logic [31:0] r;
    r = '0;
    if (a[11:7] == 5'd1) begin
      b = int'(a[6:5]);
      if (b < NB) begin
        case (a[4:2])
          3'd0: r = m_in[b*LN +: LN];
          3'd1: r = m_mask[b*LN +: LN];
          3'd4: r = m_swi[b*LN +: LN];
          3'd6: r = m_pend[b*LN +: LN] & ~m_mask[b*LN +: LN] & ~m_steer[b*LN +: LN];
          3'd7: r = m_pend[b*LN +: LN] & ~m_mask[b*LN +: LN] & m_steer[b*LN +: LN];
          default: r = '0;
        endcase
      end
    end else if (int'(a[11:7]) >= 2 && int'(a[11:7]) < 2 + NB) begin
      b = int'(a[11:7]) - 2;
      r[PW+1:0] = {m_prio[b][a[6:2]], 1'b0, m_steer[b*LN + int'(a[6:2])]};
    end else begin
      case (a[11:2])
        10'd0:  r = 32'h21;
        10'd4:  r[0] = m_ai;
        10'd5:  r[0] = 1'b1;
        10'd18: r[2] = m_gm;
        10'd20: r[1:0] = m_idle;
        default: r = '0;
      endcase
    end
    return r;
  endfunction

  task automatic m_step(logic we, logic [11:0] a, logic [31:0] d, logic [W-1:0] irq);
    logic [W-1:0] up, dn;
    int b;
    up = irq & ~m_in;
    dn = ~irq & m_in;
    for (int k = 0; k < NB; k++) begin
      if (|dn[k*LN +: LN]) m_pend[k*LN +: LN] = irq[k*LN +: LN] | m_swi[k*LN +: LN];
      else m_pend[k*LN +: LN] = m_pend[k*LN +: LN] | up[k*LN +: LN];
    end
    m_in = irq;
    m_ev = |up;
    m_rn = we && a[11:2] == 10'd18 && d[0];
    m_rf = we && a[11:2] == 10'd18 && d[1];
    if (we) begin
      if (a[11:7] == 5'd1) begin
        b = int'(a[6:5]);
        if (b < NB) begin
          case (a[4:2])
            3'd1: begin m_mask[b*LN +: LN] = d; m_ev = 1'b1; end
            3'd2: begin m_mask[b*LN +: LN] &= ~d; m_ev = 1'b1; end
            3'd3: m_mask[b*LN +: LN] |= d;
            3'd4: begin
              m_swi[b*LN +: LN] |= d;
              m_pend[b*LN +: LN] |= m_swi[b*LN +: LN];
              m_ev = 1'b1;
            end
            3'd5: begin
              m_swi[b*LN +: LN] &= ~d;
              m_pend[b*LN +: LN] = m_swi[b*LN +: LN] & m_in[b*LN +: LN];
            end
            default: ;
          endcase
        end
      end else if (int'(a[11:7]) >= 2 && int'(a[11:7]) < 2 + NB) begin
        b = int'(a[11:7]) - 2;
        m_prio[b][a[6:2]] = d[7:2];
        m_steer[b*LN + int'(a[6:2])] = d[0];
      end else begin
        case (a[11:2])
          10'd4:  if (d[1]) m_reset(); else m_ai = d[0];
          10'd18: m_gm = d[2];
          10'd20: m_idle = d[1:0];
          default: ;
        endcase
      end
    end
  endtask

  task automatic cyc(logic we, logic re, logic [11:0] a, logic [31:0] d);
    logic [31:0] er;
    wr_en = we; rd_en = re; addr = a; wdata = d;
    er = m_read(a);
    @(posedge clk);
    m_step(we, a, d, irq_in);
    @(negedge clk);
    if (re) chk("R13 read data", rdata, er);
    chk("R2/R3/R4 pending", pend_o, m_pend);
    chk("R5 mask", mask_o, m_mask);
    chk("R5 eval pulse", eval_o, m_ev);
    chk("R7 steer", steer_o, m_steer);
    chk("R10 rearm strobes", {rearm_fast_o, rearm_norm_o}, {m_rf, m_rn});
    chk("R10 global mask", glob_mask_o, m_gm);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d); cyc(1'b1, 1'b0, a, d); endtask
  task automatic rd(logic [11:0] a); cyc(1'b0, 1'b1, a, 32'h0); endtask
  task automatic idle(); cyc(1'b0, 1'b0, 12'h0, 32'h0); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4021));
    m_reset();
    m_rn = 1'b0; m_rf = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mask reset", mask_o, {W{1'b1}});
    chk("R1 pending reset", pend_o, '0);
    chk("R1 steer reset", steer_o, '0);
    chk("R1 prio reset", prio_o, '0);
    chk("R1 strobes reset", {glob_mask_o, rearm_norm_o, rearm_fast_o, eval_o}, 4'b0);

    rd(12'h000); chk("R8 revision", rdata, 32'h21);
    rd(12'h014); chk("R8 status", rdata, 32'h1);
    rd(12'h04C); chk("R8 protection", rdata, 32'h0);
    wr(12'h050, 32'hFF); rd(12'h050); chk("R11 idle", rdata, 32'h3);
    wr(12'h010, 32'h1); rd(12'h010); chk("R9 autoidle", rdata, 32'h1);

    wr(12'h048, 32'h7);
    chk("R10 rearm and global mask", {rearm_fast_o, rearm_norm_o, glob_mask_o}, 3'b111);
    idle();
    chk("R10 rearm one cycle", {rearm_fast_o, rearm_norm_o}, 2'b00);
    rd(12'h048); chk("R10 global mask readback", rdata, 32'h4);
    wr(12'h048, 32'h0);

    irq_in[37] = 1'b1; idle();
    chk("R2 rise sets pending", pend_o[37], 1'b1);
    chk("R2 rise pulses eval", eval_o, 1'b1);
    rd(12'h0A0); chk("R2 raw input view", rdata, 32'h20);
    wr(12'h0AC, 32'h20); chk("R5 mask-set no eval", eval_o, 1'b0);
    wr(12'h0A8, 32'hFFFF_FFFF); chk("R5 mask-clear eval", eval_o, 1'b1);
    rd(12'h0B8); chk("R6 normal view", rdata, 32'h20);
    irq_in[37] = 1'b0; idle();
    chk("R3 fall clears pending", pend_o[63:32], 32'h0);

    wr(12'h21C, 32'hFF);
    rd(12'h21C); chk("R7 config readback", rdata, 32'hFD);
    chk("R7 prio output", prio_o[(2*LN+7)*PW +: PW], 6'h3F);
    chk("R7 steer output", steer_o[71], 1'b1);
    wr(12'h0C8, 32'hFFFF_FFFF);
    wr(12'h0D0, 32'h80);
    rd(12'h0DC); chk("R6 fast view", rdata, 32'h80);
    rd(12'h0D8); chk("R6 normal view excludes fast", rdata, 32'h0);
    rd(12'h0D0); chk("R4 software readback", rdata, 32'h80);

    irq_in[3] = 1'b1; idle();
    wr(12'h090, 32'h18); chk("R4 software set", pend_o[31:0], 32'h18);
    wr(12'h094, 32'h10); chk("R4 software clear keeps sw&input", pend_o[31:0], 32'h08);
    wr(12'h094, 32'h08); chk("R4 software clear drops input line", pend_o[31:0], 32'h00);
    irq_in[3] = 1'b0; idle();

    wr(12'h0E4, 32'h0); chk("R12 bad bank write", mask_o[31:0], 32'hFFFF_FFFF);
    rd(12'h0E4); chk("R12 bad bank read", rdata, 32'h0);
    wr(12'h080, 32'hFFFF_FFFF); rd(12'h080); chk("R12 raw view read-only", rdata, 32'h0);
    wr(12'h000, 32'h55); rd(12'h000); chk("R12 revision read-only", rdata, 32'h21);

    wr(12'h050, 32'h2);
    wr(12'h010, 32'h2);
    chk("R9 soft reset mask", mask_o, {W{1'b1}});
    chk("R9 soft reset steer", steer_o, '0);
    rd(12'h050); chk("R9 soft reset idle", rdata, 32'h0);
    rd(12'h21C); chk("R9 soft reset config", rdata, 32'h0);

    for (int i = 0; i < 4000; i++) begin
      logic [11:0] a;
      logic [31:0] d;
      int sel;
      irq_in = irq_in ^ ({$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom}
                       & {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom});
      sel = $urandom_range(0, 9);
      d = $urandom;
      case ($urandom_range(0, 2))
        0: a = {5'd1, 2'($urandom_range(0, 3)), 3'($urandom_range(0, 7)), 2'b00};
        1: a = {5'($urandom_range(2, 4)), 5'($urandom), 2'b00};
        default: begin
          case ($urandom_range(0, 6))
            0: a = 12'h000; 1: a = 12'h010; 2: a = 12'h014; 3: a = 12'h048;
            4: a = 12'h04C; 5: a = 12'h050; default: a = 12'h040;
          endcase
        end
      endcase
      if (a == 12'h010) d[1] = (i % 700 == 0);
      if (sel < 4) idle();
      else if (sel < 8) wr(a, d);
      else rd(a);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule